// File: doc/BRIEF.md
# Serial EEPROM Calibration Programmer

This block writes a calibration image of 2^ADDR_W bits into a bit-addressable serial EEPROM and then checks what was stored. It never shifts bits on a pin itself. It hands 16-bit control words, one at a time, to a downstream serial shifter over a valid/ready pair. When the shifter returns a read bit, it pulses `rd_valid` together with that bit.

A `start` pulse captures the image and begins the run. The run starts with a no-op word and one erase word. It then waits a programmable cycle count and sends a second no-op. After that it walks the addresses in ascending order.

- For each address whose image bit is 1, it sends an address-primed no-op, then a write-bit word, then waits the settle delay, then sends a closing no-op with the same address.
- Addresses whose image bit is 0 cost only one scan cycle, because the erase has already cleared those cells.

Once the programming pass ends, every address is read back in ascending order and compared with the captured image. The first mismatch sets a sticky fail flag and latches its address. A one-cycle `done` pulse closes the run.

Top module: `eep_prog_seq`

## Requirements
- R1: While reset is high and after its release, `busy`, `done`, `vfail` and `cmd_valid` are low until a start is accepted.
- R2: A run opens with the words 0x0000 and 0x1000, then a wait, then 0x0000.
- R3: Addresses are handled in ascending order. For each address A (0 to 2^ADDR_W-1) whose image bit is 1, the block sends 0x00A, then 0x20A, then waits, then sends 0x00A again. An address whose image bit is 0 produces no word in this phase.
- R4: After the handshake of an erase word or a write-bit word, no word is offered for WAIT_CYC cycles. The next handshake therefore comes at least WAIT_CYC+1 clock edges after the previous one.
- R5: In every word, bits [15:12] hold the operation (0 no-op, 1 erase, 2 write bit, 3 read bit), bits [6:0] hold the bit address, and bits [11:7] are zero.
- R6: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` stays high and `cmd_word` does not change. Each handshake consumes exactly one word.
- R7: After programming, the block sends a read word 0x30A for every address in ascending order. It waits for `rd_valid` before offering the next read word.
- R8: On a read-back mismatch with the captured image, `vfail` rises and `fail_addr` takes the lowest mismatched address. Later mismatches change neither output. Both are cleared when the next start is accepted.
- R9: `done` is a one-cycle pulse that follows the last read result. `busy` is low in that same cycle.
- R10: A start pulse while `busy` is high is ignored. The image is sampled only when a start is accepted, so later changes to the `image` input have no effect on the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Run request pulse |
| image | input | 2^ADDR_W | Calibration image; bit i is the value for address i |
| cmd_valid | output | 1 | A control word is offered |
| cmd_ready | input | 1 | The shifter accepts the offered word |
| cmd_word | output | 16 | Control word: operation in [15:12], address in [6:0] |
| rd_valid | input | 1 | A read-back bit is returned |
| rd_bit | input | 1 | Returned EEPROM bit |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| vfail | output | 1 | Read-back mismatch seen in the latest run |
| fail_addr | output | ADDR_W | Lowest mismatched address |

## Verification
The following hold cycle by cycle and are checked that way:
- a word stalled by `cmd_ready` stays frozen;
- no word is offered while the settle timer runs, and the timer counts down one step per cycle;
- the pad bits of every word are zero;
- the captured image and the fail record are stable;
- `done` is a single-cycle pulse with `busy` low.

Only the bench scenarios can show the rest. These are the exact word stream for each image, including skipped zero bits and the first and last addresses, and the handshake gap after erase and write words. They also cover lowest-address selection with several faulty cells, stuck-at-one cells that read back where a zero was intended, and a start pulse and image change in the middle of a run having no effect.

// File: rtl/eep_seq_pkg.sv
package eep_seq_pkg;

  localparam int CMD_W = 16;

  localparam logic [3:0] OP_NOP   = 4'h0;
  localparam logic [3:0] OP_ERASE = 4'h1;
  localparam logic [3:0] OP_WRBIT = 4'h2;
  localparam logic [3:0] OP_RDBIT = 4'h3;

  typedef enum logic [3:0] {
    S_IDLE,
    S_NOP0,
    S_ERASE,
    S_EWAIT,
    S_NOP1,
    S_SCAN,
    S_PRIME,
    S_WRITE,
    S_WWAIT,
    S_POST,
    S_RDREQ,
    S_RDWAIT
  } seq_state_t;

  function automatic logic is_send(seq_state_t s);
    return (s == S_NOP0) || (s == S_ERASE) || (s == S_NOP1) ||
           (s == S_PRIME) || (s == S_WRITE) || (s == S_POST) ||
           (s == S_RDREQ);
  endfunction

  function automatic logic [3:0] op_of(seq_state_t s);
    case (s)
      S_ERASE: return OP_ERASE;
      S_WRITE: return OP_WRBIT;
      S_RDREQ: return OP_RDBIT;
      default: return OP_NOP;
    endcase
  endfunction

endpackage

// File: rtl/eep_wait_timer.sv
module eep_wait_timer #(
  parameter int WAIT_CYC = 500000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic active,
  output logic expire
);
  localparam int CNT_W = $clog2(WAIT_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WAIT_CYC);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= LOAD_VAL;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);
  assign expire = (cnt == CNT_W'(1));

  AST_TMR_STEP: assert property (@(posedge clk) disable iff (rst)
    active && !load |=> cnt == $past(cnt) - 1'b1); // R4

  AST_TMR_NO_RELOAD: assert property (@(posedge clk) disable iff (rst)
    load |-> !active); // R4

endmodule

// File: rtl/eep_word_fmt.sv
module eep_word_fmt #(
  parameter int ADDR_W = 7
) (
  input  logic [3:0]        op,
  input  logic [ADDR_W-1:0] addr,
  output logic [15:0]       word
);
  localparam int PAD_W = 12 - ADDR_W;

  assign word = {op, {PAD_W{1'b0}}, addr};

endmodule

// File: rtl/eep_verify_unit.sv
module eep_verify_unit #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              check,
  input  logic              exp_bit,
  input  logic              got_bit,
  input  logic [ADDR_W-1:0] addr,
  output logic              vfail,
  output logic [ADDR_W-1:0] fail_addr
);
  logic miss;
  assign miss = check && (exp_bit != got_bit);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      vfail     <= 1'b0;
      fail_addr <= '0;
    end else if (miss && !vfail) begin
      vfail     <= 1'b1;
      fail_addr <= addr;
    end
  end

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
    vfail && !clear |=> vfail && $stable(fail_addr)); // R8

  AST_FAIL_CAUSE: assert property (@(posedge clk) disable iff (rst)
    !vfail && !miss |=> !vfail); // R8

endmodule

// File: rtl/eep_prog_seq.sv
module eep_prog_seq
  import eep_seq_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int WAIT_CYC = 500000,
  localparam int NBITS   = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [NBITS-1:0]  image,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [15:0]       cmd_word,
  input  logic              rd_valid,
  input  logic              rd_bit,
  output logic              busy,
  output logic              done,
  output logic              vfail,
  output logic [ADDR_W-1:0] fail_addr
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NBITS - 1);

  seq_state_t        state, nxt;
  logic [ADDR_W-1:0] addr, nxt_addr;
  logic [NBITS-1:0]  img_q;
  logic              hs, tmr_load, tmr_active, tmr_expire;
  logic              take_img, chk, fin;
  logic [15:0]       nxt_word;

  assign hs = cmd_valid && cmd_ready;

  eep_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .load   (tmr_load),
    .active (tmr_active),
    .expire (tmr_expire)
  );

  eep_word_fmt #(.ADDR_W(ADDR_W)) u_fmt (
    .op   (op_of(nxt)),
    .addr (nxt_addr),
    .word (nxt_word)
  );

  eep_verify_unit #(.ADDR_W(ADDR_W)) u_ver (
    .clk       (clk),
    .rst       (rst),
    .clear     (take_img),
    .check     (chk),
    .exp_bit   (img_q[addr]),
    .got_bit   (rd_bit),
    .addr      (addr),
    .vfail     (vfail),
    .fail_addr (fail_addr)
  );

  always_comb begin
    nxt      = state;
    nxt_addr = addr;
    tmr_load = 1'b0;
    take_img = 1'b0;
    chk      = 1'b0;
    fin      = 1'b0;
    case (state)
      S_IDLE:
        if (start) begin
          nxt      = S_NOP0;
          nxt_addr = '0;
          take_img = 1'b1;
        end
      S_NOP0:  if (hs) nxt = S_ERASE;
      S_ERASE:
        if (hs) begin
          nxt      = S_EWAIT;
          tmr_load = 1'b1;
        end
      S_EWAIT: if (tmr_expire) nxt = S_NOP1;
      S_NOP1:  if (hs) nxt = S_SCAN;
      S_SCAN:
        if (img_q[addr]) begin
          nxt = S_PRIME;
        end else if (addr == LAST) begin
          nxt      = S_RDREQ;
          nxt_addr = '0;
        end else begin
          nxt_addr = addr + 1'b1;
        end
      S_PRIME: if (hs) nxt = S_WRITE;
      S_WRITE:
        if (hs) begin
          nxt      = S_WWAIT;
          tmr_load = 1'b1;
        end
      S_WWAIT: if (tmr_expire) nxt = S_POST;
      S_POST:
        if (hs) begin
          if (addr == LAST) begin
            nxt      = S_RDREQ;
            nxt_addr = '0;
          end else begin
            nxt      = S_SCAN;
            nxt_addr = addr + 1'b1;
          end
        end
      S_RDREQ: if (hs) nxt = S_RDWAIT;
      S_RDWAIT:
        if (rd_valid) begin
          chk = 1'b1;
          if (addr == LAST) begin
            nxt = S_IDLE;
            fin = 1'b1;
          end else begin
            nxt      = S_RDREQ;
            nxt_addr = addr + 1'b1;
          end
        end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      addr      <= '0;
      img_q     <= '0;
      cmd_valid <= 1'b0;
      cmd_word  <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      state     <= nxt;
      addr      <= nxt_addr;
      if (take_img) img_q <= image;
      cmd_valid <= is_send(nxt);
      cmd_word  <= nxt_word;
      busy      <= (nxt != S_IDLE);
      done      <= fin;
    end
  end

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_word)); // R6

  AST_QUIET_IN_WAIT: assert property (@(posedge clk) disable iff (rst)
    tmr_active |-> !cmd_valid); // R4

  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> cmd_word[11:ADDR_W] == '0); // R5

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9

  AST_IMG_HELD: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(img_q)); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !cmd_valid); // R1

endmodule

// File: tb/sim_eep_prog_seq.sv
module sim_eep_prog_seq;
  localparam int AW  = 7;
  localparam int NB  = 1 << AW;
  localparam int W   = 6;
  localparam int LAT = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [NB-1:0] image = '0;
  logic          cmd_valid;
  logic          cmd_ready = 1'b0;
  logic [15:0]   cmd_word;
  logic          rd_valid = 1'b0;
  logic          rd_bit = 1'b0;
  logic          busy, done, vfail;
  logic [AW-1:0] fail_addr;

  always #10 clk = ~clk;

  eep_prog_seq #(.ADDR_W(AW), .WAIT_CYC(W)) u0 (
    .clk(clk), .rst(rst), .start(start), .image(image),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_word(cmd_word),
    .rd_valid(rd_valid), .rd_bit(rd_bit), .busy(busy), .done(done),
    .vfail(vfail), .fail_addr(fail_addr)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // EEPROM and shifter model
  logic          cells [NB];
  logic [NB-1:0] s0 = '0;
  logic [NB-1:0] s1 = '0;
  logic [15:0]   expq[$];
  int            idx = 0;
  int            rd_pend = 0;
  logic          rd_next = 1'b0;
  logic [15:0]   lfsr = 16'hACE1;
  bit            rdy_always = 0;
  int            last_cyc = 0;
  logic [3:0]    last_op = 4'h0;
  bit            pend_hold = 0;
  logic [15:0]   hold_word = '0;

  task automatic take_word(input logic [15:0] w);
    string req;
    int a;
    a = int'(w[AW-1:0]);
    if (idx < expq.size()) begin
      if (idx < 3) req = "R2 opening word";
      else if (expq[idx][15:12] == 4'h3) req = "R7 read word";
      else req = "R3 program word";
      chk(req, {16'h0, w}, {16'h0, expq[idx]});
    end else begin
      chk("R3 surplus word", 32'd1, 32'd0);
    end
    idx++;
    if (last_op == 4'h1 || last_op == 4'h2)
      chk("R4 gap after erase/write", 32'(cyc - last_cyc >= W + 1), 32'd1);
    last_op  = w[15:12];
    last_cyc = cyc;
    chk("R5 pad bits", 32'(w[11:7]), 32'd0);
    case (w[15:12])
      4'h1: foreach (cells[i]) cells[i] = 1'b0;
      4'h2: cells[a] = 1'b1;
      4'h3: begin
        rd_pend = LAT;
        rd_next = s1[a] ? 1'b1 : (s0[a] ? 1'b0 : cells[a]);
      end
      default: ;
    endcase
  endtask

  always @(negedge clk) begin
    if (rst) begin
      cmd_ready = 1'b0;
      rd_valid  = 1'b0;
      pend_hold = 0;
    end else begin
      if (pend_hold)
        chk("R6 stalled word held", {15'h0, cmd_valid, cmd_word}, {15'h0, 1'b1, hold_word});
      rd_valid = 1'b0;
      if (rd_pend > 0) begin
        rd_pend--;
        if (rd_pend == 0) begin
          rd_valid = 1'b1;
          rd_bit   = rd_next;
        end
      end
      lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cmd_ready = rdy_always | lfsr[0] | lfsr[3];
      pend_hold = cmd_valid && !cmd_ready;
      hold_word = cmd_word;
      if (cmd_valid && cmd_ready) take_word(cmd_word);
    end
  end

  task automatic build(input logic [NB-1:0] img);
    expq.delete();
    expq.push_back(16'h0000);
    expq.push_back(16'h1000);
    expq.push_back(16'h0000);
    for (int a = 0; a < NB; a++) begin
      if (img[a]) begin
        expq.push_back(16'h0000 | 16'(a));
        expq.push_back(16'h2000 | 16'(a));
        expq.push_back(16'h0000 | 16'(a));
      end
    end
    for (int a = 0; a < NB; a++) expq.push_back(16'h3000 | 16'(a));
  endtask

  task automatic run_case(input logic [NB-1:0] img, input logic [NB-1:0] m0,
                          input logic [NB-1:0] m1, input bit restart);
    logic [NB-1:0] mism;
    int            first;
    int            t;
    s0 = m0;
    s1 = m1;
    build(img);
    idx     = 0;
    last_op = 4'h0;
    @(negedge clk);
    image = img;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 busy after accepted start", 32'(busy), 32'd1);
    t = 0;
    while (!done && t < 20000) begin
      @(negedge clk);
      t++;
      if (restart && t == 40) begin
        image = ~img;
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    if (!done) chk("R9 done never seen", 32'd0, 32'd1);
    chk("R9 busy low with done", 32'(busy), 32'd0);
    chk("R7 total word count", 32'(idx), 32'(expq.size()));
    mism  = (m0 & img) | (m1 & ~img);
    first = 0;
    for (int a = NB - 1; a >= 0; a--) if (mism[a]) first = a;
    chk("R8 vfail", 32'(vfail), 32'(mism != '0));
    if (mism != '0) chk("R8 first fail address", 32'(fail_addr), 32'(first));
    @(negedge clk);
    chk("R9 done is one cycle", 32'(done), 32'd0);
    chk("R10 idle after run", 32'(busy), 32'd0);
  endtask

  initial begin
    foreach (cells[i]) cells[i] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", 32'(busy), 32'd0);
    chk("R1 done in reset", 32'(done), 32'd0);
    chk("R1 vfail in reset", 32'(vfail), 32'd0);
    chk("R1 cmd_valid in reset", 32'(cmd_valid), 32'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", {30'h0, busy, cmd_valid}, 32'd0);

    // R3: all-zero image writes nothing
    run_case('0, '0, '0, 0);
    // R3: every bit set
    run_case('1, '0, '0, 0);
    // R3: alternating pattern
    run_case({(NB/2){2'b01}}, '0, '0, 0);
    // R3: first and last addresses only
    rdy_always = 1;
    run_case((NB'(1) << (NB - 1)) | NB'(1), '0, '0, 0);
    rdy_always = 0;
    // mixed pattern
    run_case({4{32'hA3C1_5E7D}}, '0, '0, 0);
    // R8: stuck-at-0 at 40 and 90, stuck-at-1 at 100 (image 0 there)
    run_case(~(NB'(1) << 100), (NB'(1) << 40) | (NB'(1) << 90), NB'(1) << 100, 0);
    // R8: stuck-at-1 only, first reported is lowest zero-bit address
    run_case({(NB/4){4'b0111}}, '0, (NB'(1) << 7) | (NB'(1) << 3), 0);
    // R10: start and image change mid-run ignored; R8 cleared by new start
    run_case({2{64'h0F0F_3C3C_8001_FFEE}}, '0, '0, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule